// File: doc/BRIEF.md
# Serial Flash SPI Master Controller

This block is a register-mapped, single-data-line SPI master meant to talk to serial NOR flash devices. Software pushes 32-bit words into a transmit FIFO through one of four write ports. Each port fixes how many bytes of the written word go out on the wire: all four, or only the lowest one, two or three. A shift engine serialises those bytes in SPI mode 0, using a clock divided down from the core clock by a power of two. For every byte it sends, it captures one byte from the data input. The captured bytes are gathered back into words and placed in a receive FIFO, which software drains by reading a data register.

Chip select is either generated automatically around activity or held by software through a control bit. Holding it under software control lets a single flash command span many FIFO words. An interrupt unit exposes the FIFO levels and two sticky error conditions. A set/clear mask pair chooses which of them raise the interrupt line.

Register offsets (byte addresses on an 8-bit address bus): control 0x00, enable 0x04, status 0x08, mask-set 0x0C, mask-clear 0x10, mask read 0x14, transmit threshold 0x18, transmit ports 0x20/0x24/0x28/0x2C, receive data 0x30. A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled.

Top module: `spi_flash_ctrl`

## Requirements
- R1: Control bits [2:0] hold a divider code d; one SCLK period lasts 2<<d core clock cycles, so the divisors run from 2 to 256.
- R2: SPI mode 0 is used: SCLK idles low, MOSI changes only after a falling edge, and MISO is sampled on the rising edge. Each byte goes out MSB first, and the bytes of a word go out least significant byte first.
- R3: A write to 0x20 queues all 4 bytes of the word. Writes to 0x24, 0x28 and 0x2C queue only the low 1, 2 or 3 bytes.
- R4: Each byte sent brings one byte back. The received bytes of a word are packed in send order into the high byte lanes of a 32-bit receive word, and unused low lanes read as zero; a full word therefore has byte k in lane k.
- R5: The status register at 0x08 has these bits: 0 receive overflow, 2 transmit-not-full, 3 transmit full, 4 receive not empty, 5 receive full, 6 transmit underflow. Bit 2 is set while the transmit FIFO holds fewer entries than the threshold at 0x18.
- R6: Status bits 0 and 6 stay set until software writes 1 to that bit at 0x08. Writing 0 leaves them unchanged.
- R7: Writing 1s to 0x0C sets mask bits and writing 1s to 0x10 clears them. 0x14 reads the mask back. The irq output is high when any status bit is high together with its mask bit.
- R8: Control bit 4 selects manual chip select. In manual mode, cs_n follows control bit 3, and shifting only advances while cs_n is low. In automatic mode, cs_n is low exactly while a word is being shifted.
- R9: Bit 0 of 0x04 enables the controller. While it is 0, SCLK does not toggle and no word is started.
- R10: Each FIFO holds 63 words. A transmit write while the transmit FIFO is full is discarded. A received word that arrives while the receive FIFO is full is discarded and sets status bit 0.
- R11: In manual mode with cs_n low, status bit 6 is set when a word finishes and the transmit FIFO is empty. SCLK then stays low until more data arrives.
- R12: After reset: cs_n=1, sclk=0, irq=0, status=0x04, mask=0, enable=0, threshold=1, and manual chip select is off with control bit 3 at 1. Reading 0x30 removes one word, and returns 0 when the receive FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is receive overflow. It needs the receive FIFO completely full at the moment another word completes on the wire, while the transmit side keeps feeding the engine. The bench gets there in steps. With the engine disabled, it first fills the transmit FIFO to its full mark, which also exercises the threshold and full flags. It then enables shifting and lets the 63 words land in the receive FIFO. Finally it queues one more single-byte word, whose receive word must be dropped with the sticky overflow flag set, and it drains the FIFO to prove that the first word returned is still the oldest one. The MISO line is the inverse of MOSI, so every returned byte can be predicted, and swapped bit or lane orders show up.

// File: rtl/sfc_pkg.sv
// Shared constants and types for the serial flash SPI master.
// Assumes a byte-addressed 8-bit register bus and 32-bit data words.
package sfc_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int ST_W   = 7;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENA   = 8'h04;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] A_MSET  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_MCLR  = 8'h10;
    localparam logic [ADDR_W-1:0] A_MASK  = 8'h14;
    localparam logic [ADDR_W-1:0] A_TXTH  = 8'h18;
    localparam logic [ADDR_W-1:0] A_TX4   = 8'h20;
    localparam logic [ADDR_W-1:0] A_TX1   = 8'h24;
    localparam logic [ADDR_W-1:0] A_TX2   = 8'h28;
    localparam logic [ADDR_W-1:0] A_TX3   = 8'h2C;
    localparam logic [ADDR_W-1:0] A_RXD   = 8'h30;

    // Status bit positions; software decodes these.
    localparam int SB_RXOVF  = 0;
    localparam int SB_TXNF   = 2;
    localparam int SB_TXFULL = 3;
    localparam int SB_RXNE   = 4;
    localparam int SB_RXFULL = 5;
    localparam int SB_TXUDF  = 6;

    // Transmit FIFO entry: byte count minus one, then the data word.
    typedef struct packed {
        logic [1:0]        nm1;
        logic [WORD_W-1:0] data;
    } tx_entry_t;
endpackage

// File: rtl/sfc_fifo.sv
// Synchronous FIFO with occupancy count.
// Assumes: push while full is dropped unless a pop happens in the same
// cycle; pop while empty is ignored; read data is the head entry.
module sfc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rp];

    // Storage write; no reset needed for payload.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and count maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/sfc_shift.sv
// SPI mode-0 shift engine. Takes one FIFO word at a time, sends its
// valid bytes LSB byte first / MSB bit first, and packs each returned
// byte into the high lanes of a receive word. Assumes `run` already
// combines the global enable and the chip-select gate; when low, all
// state freezes.
module sfc_shift #(
    parameter int DIV_BITS = 3,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [DIV_BITS-1:0] div,
    input  logic                tx_avail,
    input  logic [WORD_W-1:0]   tx_data,
    input  logic [1:0]          tx_nm1,
    input  logic                miso,
    output logic                tx_pop,
    output logic                sclk,
    output logic                mosi,
    output logic                busy,
    output logic                rx_push,
    output logic [WORD_W-1:0]   rx_word,
    output logic                starve
);
    localparam int HW = 2**DIV_BITS;

    logic [HW-1:0]       cnt, half_lim;
    logic [2:0]          bit_cnt;
    logic [1:0]          left;
    logic [7:0]          cur, rxb;
    logic [WORD_W-9:0]   rest;
    logic [WORD_W-1:0]   rxw;
    logic                tick, rise, fall, byte_end, word_end, load;

    assign half_lim = (HW'(1) << div) - 1'b1;
    assign tick     = busy && run && (cnt == half_lim);
    assign rise     = tick && !sclk;
    assign fall     = tick && sclk;
    assign byte_end = fall && (bit_cnt == 3'd7);
    assign word_end = byte_end && (left == 2'd0);
    assign load     = (!busy || word_end) && run && tx_avail;

    assign tx_pop   = load;
    assign rx_push  = word_end;
    assign rx_word  = {rxb, rxw[WORD_W-1:8]};
    assign starve   = word_end && !tx_avail;
    assign mosi     = busy ? cur[7] : 1'b0;

    // Word load, half-period timing, bit shifting and byte packing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            cnt     <= '0;
            bit_cnt <= '0;
            left    <= '0;
            cur     <= '0;
            rest    <= '0;
            rxb     <= '0;
            rxw     <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            sclk    <= 1'b0;
            cnt     <= '0;
            bit_cnt <= '0;
            left    <= tx_nm1;
            cur     <= tx_data[7:0];
            rest    <= tx_data[WORD_W-1:8];
            rxw     <= '0;
        end else if (word_end) begin
            busy <= 1'b0;
            sclk <= 1'b0;
            cnt  <= '0;
        end else if (busy && run) begin
            if (tick) begin
                cnt  <= '0;
                sclk <= ~sclk;
                if (rise) begin
                    rxb <= {rxb[6:0], miso};
                end else if (byte_end) begin
                    bit_cnt <= '0;
                    left    <= left - 1'b1;
                    cur     <= rest[7:0];
                    rest    <= {8'h00, rest[WORD_W-9:8]};
                    rxw     <= {rxb, rxw[WORD_W-1:8]};
                end else begin
                    cur     <= {cur[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> (!sclk || $stable(mosi)));
    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(sclk));
endmodule

// File: rtl/sfc_irq.sv
// Interrupt mask with set/clear write ports and a registered request.
// Assumes raw status is level; the request follows one cycle later.
module sfc_irq #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask,
    output logic         irq
);
    // Mask bit set/clear and request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            if (set_wr)      mask <= mask | wdata;
            else if (clr_wr) mask <= mask & ~wdata;
            irq <= |(raw & mask);
        end
    end

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(mask));
endmodule

// File: rtl/spi_flash_ctrl.sv
// Serial flash SPI master top: register file, transmit/receive FIFOs,
// shift engine, sticky error flags and interrupt unit. Assumes a simple
// single-cycle write strobe and a read strobe whose data returns in the
// next cycle; reading the receive data register consumes one word.
module spi_flash_ctrl
    import sfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int DIV_BITS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    localparam int CW  = $clog2(FIFO_DEPTH+1);
    localparam int TXW = $bits(tx_entry_t);

    logic [DIV_BITS-1:0] div_q;
    logic                cs_lvl_q, cs_force_q, ena_q;
    logic [CW-1:0]       thr_q;
    logic                ovf_q, udf_q;

    tx_entry_t           tx_in, tx_head;
    logic [TXW-1:0]      tx_head_raw;
    logic                tx_push, tx_pop, tx_full, tx_empty;
    logic [CW-1:0]       tx_cnt;
    logic                rx_push, rx_pop, rx_full, rx_empty;
    logic [CW-1:0]       rx_cnt;
    logic [WORD_W-1:0]   rx_word, rx_head;
    logic                busy, starve, run, cs_gate;
    logic [ST_W-1:0]     status, mask;
    logic                stat_wr;

    // Bus decode
    assign stat_wr = bus_wr && (bus_addr == A_STAT);
    assign tx_push = bus_wr && ((bus_addr == A_TX4) || (bus_addr == A_TX1) ||
                                (bus_addr == A_TX2) || (bus_addr == A_TX3));
    assign rx_pop  = bus_rd && (bus_addr == A_RXD) && !rx_empty;

    // Byte count for the selected transmit port.
    always_comb begin
        tx_in.data = bus_wdata;
        case (bus_addr)
            A_TX1:   tx_in.nm1 = 2'd0;
            A_TX2:   tx_in.nm1 = 2'd1;
            A_TX3:   tx_in.nm1 = 2'd2;
            default: tx_in.nm1 = 2'd3;
        endcase
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q      <= '0;
            cs_lvl_q   <= 1'b1;
            cs_force_q <= 1'b0;
            ena_q      <= 1'b0;
            thr_q      <= CW'(1);
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    div_q      <= bus_wdata[DIV_BITS-1:0];
                    cs_lvl_q   <= bus_wdata[3];
                    cs_force_q <= bus_wdata[4];
                end
                A_ENA:  ena_q <= bus_wdata[0];
                A_TXTH: thr_q <= bus_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    // Chip select and run gating
    assign cs_gate = cs_force_q ? !cs_lvl_q : 1'b1;
    assign run     = ena_q && cs_gate;
    assign cs_n    = cs_force_q ? cs_lvl_q : !busy;

    sfc_fifo #(.W(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_in),
        .pop(tx_pop), .rdata(tx_head_raw), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty));
    assign tx_head = tx_head_raw;

    sfc_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty));

    sfc_shift #(.DIV_BITS(DIV_BITS), .WORD_W(WORD_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
        .tx_avail(!tx_empty), .tx_data(tx_head.data), .tx_nm1(tx_head.nm1),
        .miso(miso), .tx_pop(tx_pop), .sclk(sclk), .mosi(mosi),
        .busy(busy), .rx_push(rx_push), .rx_word(rx_word), .starve(starve));

    // Sticky error flags: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (rx_push && rx_full && !rx_pop)            ovf_q <= 1'b1;
            else if (stat_wr && bus_wdata[SB_RXOVF])      ovf_q <= 1'b0;
            if (starve && cs_force_q && !cs_lvl_q)        udf_q <= 1'b1;
            else if (stat_wr && bus_wdata[SB_TXUDF])      udf_q <= 1'b0;
        end
    end

    // Status vector assembly
    always_comb begin
        status            = '0;
        status[SB_RXOVF]  = ovf_q;
        status[SB_TXNF]   = (tx_cnt < thr_q);
        status[SB_TXFULL] = tx_full;
        status[SB_RXNE]   = !rx_empty;
        status[SB_RXFULL] = rx_full;
        status[SB_TXUDF]  = udf_q;
    end

    sfc_irq #(.N(ST_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .raw(status),
        .set_wr(bus_wr && (bus_addr == A_MSET)),
        .clr_wr(bus_wr && (bus_addr == A_MCLR)),
        .wdata(bus_wdata[ST_W-1:0]), .mask(mask), .irq(irq));

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  bus_rdata <= WORD_W'({cs_force_q, cs_lvl_q, div_q});
                A_ENA:   bus_rdata <= WORD_W'(ena_q);
                A_STAT:  bus_rdata <= WORD_W'(status);
                A_MASK:  bus_rdata <= WORD_W'(mask);
                A_TXTH:  bus_rdata <= WORD_W'(thr_q);
                A_RXD:   bus_rdata <= rx_empty ? '0 : rx_head;
                default: bus_rdata <= '0;
            endcase
        end
    end

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(stat_wr && bus_wdata[SB_RXOVF])) |=> ovf_q);
    assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_q && !(stat_wr && bus_wdata[SB_TXUDF])) |=> udf_q);
    assert_cs_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);
    assert_halt_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_q |=> $stable(sclk));
endmodule

// File: tb/test_spi_flash_ctrl.sv
`timescale 1ns/1ps
module test_spi_flash_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, cs_n, mosi, miso, irq;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_rise = 0, period = 0, n_rise = 0, n_bytes = 0, bitn = 0;
    int cs_bad = 0;
    logic [7:0] mon = '0;
    logic [7:0] bytes [0:1023];

    always #2.5 clk = ~clk;

    assign miso = ~mosi;

    spi_flash_ctrl i_spi_flash_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .irq(irq));

    always @(posedge clk) cyc <= cyc + 1;

    // Wire-side monitor: MSB-first byte capture on rising SCLK.
    always @(posedge sclk) begin
        period    = cyc - last_rise;
        last_rise = cyc;
        n_rise++;
        if (cs_n) cs_bad++;
        mon = {mon[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
            bytes[n_bytes % 1024] = mon;
            n_bytes++;
            bitn = 0;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_quiet();
        int idle = 0;
        while (idle < 300) begin
            @(negedge clk);
            if (sclk) idle = 0; else idle++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 cs_n", 32'(cs_n), 1);
        chk("R12 sclk", 32'(sclk), 0);
        chk("R12 irq", 32'(irq), 0);
        rd(8'h08, d); chk("R12 status", d, 32'h04);
        rd(8'h14, d); chk("R12 mask", d, 0);
        rd(8'h18, d); chk("R12 threshold", d, 1);
        rd(8'h00, d); chk("R12 control", d, 32'h08);
        rd(8'h30, d); chk("R12 empty rx read", d, 0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        int b = n_bytes;
        wr(8'h00, 32'h10);
        wr(8'h04, 1);
        wr(8'h20, 32'h44332211);
        wait_quiet();
        chk("R2 byte count", n_bytes - b, 4);
        chk("R2 byte0", 32'(bytes[b]),   32'h11);
        chk("R2 byte1", 32'(bytes[b+1]), 32'h22);
        chk("R2 byte3", 32'(bytes[b+3]), 32'h44);
        rd(8'h30, d); chk("R4 full word packing", d, 32'hBBCCDDEE);
        rd(8'h08, d); chk("R11 underflow set", d & 32'h40, 32'h40);
        chk("R11 sclk idle after starve", 32'(sclk), 0);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        int b = n_bytes;
        wr(8'h24, 32'hFFFFFFAB);
        wait_quiet();
        chk("R3 one-byte port count", n_bytes - b, 1);
        chk("R3 one-byte port data", 32'(bytes[b]), 32'hAB);
        rd(8'h30, d); chk("R4 one byte high lane", d, 32'h54000000);
        b = n_bytes;
        wr(8'h28, 32'h12345678);
        wait_quiet();
        chk("R3 two-byte port count", n_bytes - b, 2);
        rd(8'h30, d); chk("R4 two bytes high lanes", d, 32'hA9870000);
        b = n_bytes;
        wr(8'h2C, 32'hDEADBEEF);
        wait_quiet();
        chk("R3 three-byte port count", n_bytes - b, 3);
        chk("R3 three-byte last", 32'(bytes[b+2]), 32'hAD);
        rd(8'h30, d); chk("R4 three bytes high lanes", d, 32'h52411000);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h08, 32'h00);
        rd(8'h08, d); chk("R6 write 0 keeps underflow", d & 32'h40, 32'h40);
        wr(8'h08, 32'h40);
        rd(8'h08, d); chk("R6 w1c clears underflow", d & 32'h41, 0);
    endtask

    task automatic t_div(input int dv);
        logic [31:0] d;
        wr(8'h00, 32'h10 | dv);
        wr(8'h20, 32'h0F0F0F0F);
        wait_quiet();
        chk("R1 sclk period", period, 2 << dv);
        rd(8'h30, d);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        int r, b;
        wr(8'h00, 32'h10);
        wr(8'h04, 0);
        r = n_rise;
        wr(8'h20, 32'hCAFEF00D);
        repeat (200) @(negedge clk);
        chk("R9 no sclk when disabled", n_rise - r, 0);
        rd(8'h08, d); chk("R9 nothing received when disabled", d & 32'h10, 0);
        b = n_bytes;
        wr(8'h04, 1);
        wait_quiet();
        chk("R9 resumes on enable", n_bytes - b, 4);
        rd(8'h30, d); chk("R9 data after enable", d, ~32'hCAFEF00D);
        wr(8'h08, 32'h40);
    endtask

    task automatic t_cs();
        logic [31:0] d;
        int r, b;
        wr(8'h00, 32'h18);
        chk("R8 manual release", 32'(cs_n), 1);
        r = n_rise;
        wr(8'h24, 32'h5A);
        repeat (200) @(negedge clk);
        chk("R8 no shift while released", n_rise - r, 0);
        wr(8'h00, 32'h10);
        chk("R8 manual assert", 32'(cs_n), 0);
        wait_quiet();
        rd(8'h30, d); chk("R8 byte after assert", d, 32'hA5000000);
        wr(8'h08, 32'h40);
        wr(8'h00, 32'h00);
        chk("R8 auto idle high", 32'(cs_n), 1);
        b = n_bytes;
        wr(8'h20, 32'h01020304);
        repeat (10) @(negedge clk);
        chk("R8 auto low while busy", 32'(cs_n), 0);
        wait_quiet();
        chk("R8 auto high after", 32'(cs_n), 1);
        chk("R8 auto bytes", n_bytes - b, 4);
        rd(8'h08, d); chk("R11 no underflow in auto mode", d & 32'h40, 0);
        rd(8'h30, d);
        chk("R8 cs low on every rise", cs_bad, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h0C, 32'h10);
        rd(8'h14, d); chk("R7 mask set", d, 32'h10);
        chk("R7 irq low rx empty", 32'(irq), 0);
        wr(8'h24, 32'h77);
        wait_quiet();
        chk("R7 irq on rx not empty", 32'(irq), 1);
        wr(8'h10, 32'h10);
        rd(8'h14, d); chk("R7 mask cleared", d, 0);
        chk("R7 irq drops", 32'(irq), 0);
        rd(8'h30, d);
    endtask

    task automatic t_fill();
        logic [31:0] d;
        int b;
        wr(8'h04, 0);
        wr(8'h18, 4);
        for (int i = 0; i < 3; i++) wr(8'h20, 32'h10000000 + i);
        rd(8'h08, d); chk("R5 below threshold", d & 32'h0C, 32'h04);
        wr(8'h20, 32'h10000003);
        rd(8'h08, d); chk("R5 at threshold", d & 32'h04, 0);
        for (int i = 4; i < 64; i++) wr(8'h20, 32'h10000000 + i);
        rd(8'h08, d); chk("R5 tx full flag", d & 32'h08, 32'h08);
        b = n_bytes;
        wr(8'h04, 1);
        wait_quiet();
        chk("R10 extra tx write dropped", n_bytes - b, 252);
        rd(8'h08, d); chk("R10 rx full no overflow", d & 32'h21, 32'h20);
        wr(8'h24, 32'h99);
        wait_quiet();
        rd(8'h08, d); chk("R10 overflow set", d & 32'h01, 32'h01);
        rd(8'h30, d); chk("R10 oldest word kept", d, ~32'h10000000);
        for (int i = 1; i < 63; i++) rd(8'h30, d);
        chk("R10 last kept word", d, ~32'h1000003E);
        rd(8'h08, d); chk("R6 overflow sticky after drain", d & 32'h11, 32'h01);
        wr(8'h08, 32'h01);
        rd(8'h08, d); chk("R6 overflow cleared", d & 32'h01, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_partial();
        t_w1c();
        t_div(0);
        t_div(3);
        t_div(7);
        t_enable();
        t_cs();
        t_irq();
        t_fill();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule